// File: doc/BRIEF.md
# Receive Slot Descriptor Manager

This block manages a small ring of receive buffers described by descriptors that software fills in. Each descriptor has three words: a state, a buffer base address and a byte count. They sit in a word-addressed register file that the host reads and writes over a simple request bus. The same file also holds a setup word, a management-pin word and two transmit words. The management-pin word and the transmit words are plain storage here.

Software hands a buffer to hardware by writing the value 1 (loaded) into the slot's state word. When a frame begins, the block picks the lowest-numbered loaded slot and presents that slot's base address to a write engine. When the frame finishes, the block records the frame length in the slot's count word, sets the state to 2 (pending) and pulses a receive interrupt. If no slot is loaded, the frame is dropped. If the receive-reset bit in the setup word is set, the frame is also dropped.

A registered ready indication tells the upstream source whether a frame would be accepted: either it would be stored, or it would be discarded under receive reset.

Top module: `rx_slot_mgr`

## Requirements
- R1: A synchronous reset clears every register word to zero and drives `rx_irq`, `wr_go`, `rx_ready`, `bus_err` and `bus_rdata` to zero.
- R2: The word map is as follows. Word 0 is setup, and its bit 0 is receive reset. Word 1 is management-pin storage. Slot k uses word 2+3k for state, 3+3k for base address and 4+3k for count. Word 14 is transmit address and word 15 is transmit count. Every word reads back the last value written to it. Read data appears on `bus_rdata` one cycle after the request.
- R3: A `frm_start` pulse selects the lowest-numbered slot whose state word equals 1. The following cycle shows that slot's base address on `wr_base`, with `wr_go` high.
- R4: A `frm_done` pulse for a stored frame writes `frm_len` into the selected slot's count word and the value 2 into its state word. This hardware update wins over a host write to the same word in the same cycle.
- R5: Each stored frame produces exactly one `rx_irq` pulse, one cycle wide, in the cycle after `frm_done`.
- R6: If no slot state equals 1 at `frm_start`, the frame is dropped. `wr_go` stays low, no interrupt is raised and no register changes.
- R7: If setup bit 0 is set at `frm_start`, the frame is discarded as in R6, even when slots are loaded.
- R8: `rx_ready` is high exactly when setup bit 0 is set or some slot state equals 1. It follows register changes with one cycle of latency.
- R9: The slot index and `wr_base` are latched at `frm_start`. Host writes made before `frm_done` do not redirect the frame.
- R10: A request to word 16 or above pulses `bus_err` in the next cycle and returns zero on `bus_rdata`. A write to such a word changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Host access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| bus_err | output | 1 | Out-of-range access strobe |
| frm_start | input | 1 | Frame begins (pulse) |
| frm_done | input | 1 | Frame ends (pulse) |
| frm_len | input | DATA_W | Byte length of the finished frame |
| wr_base | output | DATA_W | Base address of the latched slot |
| wr_go | output | 1 | A slot is latched for the current frame |
| rx_irq | output | 1 | Receive interrupt pulse |
| rx_ready | output | 1 | Incoming frame would be accepted |

## Verification
On every cycle, the assertions check the following:
- every interrupt is tied to a stored completion;
- the latched slot reads pending when its interrupt shows;
- dropped frames stay silent;
- receive reset blocks selection and keeps ready high;
- the latched index does not move between starts;
- error strobes match out-of-range requests and carry zero read data.

Three things are shown only by the bench scenarios:
- that the lowest loaded slot is chosen under all sixteen loaded-slot patterns;
- that the correct words are updated while their neighbours are left alone;
- that out-of-range writes and mid-frame host writes leave earlier state untouched.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int unsigned SLOT_EMPTY     = 0;
  localparam int unsigned SLOT_LOADED    = 1;
  localparam int unsigned SLOT_PENDING   = 2;
  localparam int unsigned WORD_SETUP     = 0;
  localparam int unsigned WORD_SLOT_BASE = 2;
  localparam int unsigned WORDS_PER_SLOT = 3;
  localparam int unsigned OFS_STATE      = 0;
  localparam int unsigned OFS_ADDR       = 1;
  localparam int unsigned OFS_COUNT      = 2;
  localparam int unsigned SETUP_RXRST_BIT = 0;
endpackage

// File: rtl/rxd_regfile.sv
module rxd_regfile #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 6,
  parameter int NUM_SLOTS = 4,
  parameter int IDX_W     = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             host_req,
  input  logic                             host_we,
  input  logic [ADDR_W-1:0]                host_addr,
  input  logic [DATA_W-1:0]                host_wdata,
  output logic [DATA_W-1:0]                host_rdata,
  output logic                             host_err,
  input  logic                             hw_we,
  input  logic [IDX_W-1:0]                 hw_idx,
  input  logic [DATA_W-1:0]                hw_count,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_state_o,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_addr_o,
  output logic                             rx_rst_o
);
  import rxd_pkg::*;

  localparam int NUM_WORDS = WORD_SLOT_BASE + WORDS_PER_SLOT * NUM_SLOTS + 2;
  localparam int WIDX_W    = $clog2(NUM_WORDS);

  logic [DATA_W-1:0] mem [NUM_WORDS];
  logic              in_range;
  logic [WIDX_W-1:0] host_w;
  logic [WIDX_W-1:0] st_w;
  logic [WIDX_W-1:0] cnt_w;

  assign in_range = (int'(host_addr) < NUM_WORDS);
  assign host_w   = host_addr[WIDX_W-1:0];
  assign st_w     = WIDX_W'(WORD_SLOT_BASE + WORDS_PER_SLOT * int'(hw_idx) + OFS_STATE);
  assign cnt_w    = WIDX_W'(WORD_SLOT_BASE + WORDS_PER_SLOT * int'(hw_idx) + OFS_COUNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < NUM_WORDS; w++) mem[w] <= '0;
      host_rdata <= '0;
      host_err   <= 1'b0;
    end else begin
      host_err <= host_req && !in_range;
      if (host_req && !in_range) begin
        host_rdata <= '0;
      end else if (host_req && !host_we) begin
        host_rdata <= mem[host_w];
      end
      if (host_req && host_we && in_range) begin
        mem[host_w] <= host_wdata;
      end
      // completion update placed last so it takes precedence
      if (hw_we) begin
        mem[cnt_w] <= hw_count;
        mem[st_w]  <= DATA_W'(SLOT_PENDING);
      end
    end
  end

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot_view
    assign slot_state_o[k] = mem[WORD_SLOT_BASE + WORDS_PER_SLOT * k + OFS_STATE];
    assign slot_addr_o[k]  = mem[WORD_SLOT_BASE + WORDS_PER_SLOT * k + OFS_ADDR];
  end

  assign rx_rst_o = mem[WORD_SETUP][SETUP_RXRST_BIT];
endmodule

// File: rtl/rxd_slot_pick.sv
module rxd_slot_pick #(
  parameter int DATA_W    = 32,
  parameter int NUM_SLOTS = 4,
  parameter int IDX_W     = 2
) (
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_state,
  output logic                             any_loaded,
  output logic [IDX_W-1:0]                 first_idx
);
  import rxd_pkg::*;

  logic [NUM_SLOTS-1:0] loaded_vec;

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_loaded
    assign loaded_vec[k] = (slot_state[k] == DATA_W'(SLOT_LOADED));
  end

  assign any_loaded = |loaded_vec;

  always_comb begin
    first_idx = '0;
    for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
      if (loaded_vec[k]) first_idx = IDX_W'(k);
    end
  end
endmodule

// File: rtl/rxd_frame_ctl.sv
module rxd_frame_ctl #(
  parameter int DATA_W    = 32,
  parameter int NUM_SLOTS = 4,
  parameter int IDX_W     = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             frm_start,
  input  logic                             frm_done,
  input  logic [DATA_W-1:0]                frm_len,
  input  logic                             rx_rst,
  input  logic                             any_loaded,
  input  logic [IDX_W-1:0]                 first_idx,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_addr,
  output logic [IDX_W-1:0]                 sel_idx,
  output logic                             sel_ok,
  output logic [DATA_W-1:0]                wr_base,
  output logic                             hw_we,
  output logic [DATA_W-1:0]                hw_count,
  output logic                             rx_irq,
  output logic                             rx_ready
);
  logic take;

  assign take     = !rx_rst && any_loaded;
  assign hw_we    = frm_done && sel_ok;
  assign hw_count = frm_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_idx  <= '0;
      sel_ok   <= 1'b0;
      wr_base  <= '0;
      rx_irq   <= 1'b0;
      rx_ready <= 1'b0;
    end else begin
      rx_irq   <= hw_we;
      rx_ready <= rx_rst || any_loaded;
      if (frm_start) begin
        sel_ok  <= take;
        sel_idx <= first_idx;
        wr_base <= take ? slot_addr[first_idx] : '0;
      end else if (frm_done) begin
        sel_ok  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rx_slot_mgr.sv
module rx_slot_mgr #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 6,
  parameter int NUM_SLOTS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  input  logic              frm_start,
  input  logic              frm_done,
  input  logic [DATA_W-1:0] frm_len,
  output logic [DATA_W-1:0] wr_base,
  output logic              wr_go,
  output logic              rx_irq,
  output logic              rx_ready
);
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_state;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_addr;
  logic                             rx_rst;
  logic                             any_loaded;
  logic [IDX_W-1:0]                 first_idx;
  logic [IDX_W-1:0]                 sel_idx;
  logic                             sel_ok;
  logic                             hw_we;
  logic [DATA_W-1:0]                hw_count;

  rxd_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) i_regs (
    .clk(clk), .rst(rst),
    .host_req(bus_req), .host_we(bus_we), .host_addr(bus_addr), .host_wdata(bus_wdata),
    .host_rdata(bus_rdata), .host_err(bus_err),
    .hw_we(hw_we), .hw_idx(sel_idx), .hw_count(hw_count),
    .slot_state_o(slot_state), .slot_addr_o(slot_addr), .rx_rst_o(rx_rst)
  );

  rxd_slot_pick #(.DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) i_pick (
    .slot_state(slot_state), .any_loaded(any_loaded), .first_idx(first_idx)
  );

  rxd_frame_ctl #(.DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) i_ctl (
    .clk(clk), .rst(rst),
    .frm_start(frm_start), .frm_done(frm_done), .frm_len(frm_len),
    .rx_rst(rx_rst), .any_loaded(any_loaded), .first_idx(first_idx), .slot_addr(slot_addr),
    .sel_idx(sel_idx), .sel_ok(sel_ok), .wr_base(wr_base),
    .hw_we(hw_we), .hw_count(hw_count), .rx_irq(rx_irq), .rx_ready(rx_ready)
  );

  assign wr_go = sel_ok;
endmodule

// File: rtl/rxd_checker.sv
module rxd_checker #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 6,
  parameter int NUM_SLOTS = 4,
  parameter int IDX_W     = 2
) (
  input logic                             clk,
  input logic                             rst,
  input logic                             bus_req,
  input logic [ADDR_W-1:0]                bus_addr,
  input logic [DATA_W-1:0]                bus_rdata,
  input logic                             bus_err,
  input logic                             frm_start,
  input logic                             frm_done,
  input logic                             rx_irq,
  input logic                             rx_ready,
  input logic                             rx_rst,
  input logic [IDX_W-1:0]                 sel_idx,
  input logic                             sel_ok,
  input logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_state
);
  import rxd_pkg::*;
  localparam int NUM_WORDS = WORD_SLOT_BASE + WORDS_PER_SLOT * NUM_SLOTS + 2;

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> ($past(frm_done) && $past(sel_ok)));  // R5
  AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> (slot_state[$past(sel_idx)] == DATA_W'(SLOT_PENDING)));  // R4
  AST_DROP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (frm_done && !sel_ok) |=> !rx_irq);  // R6
  AST_RST_DISCARD: assert property (@(posedge clk) disable iff (rst)
    (frm_start && rx_rst) |=> !sel_ok);  // R7
  AST_READY_RST: assert property (@(posedge clk) disable iff (rst)
    rx_rst |=> rx_ready);  // R8
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (rst)
    !frm_start |=> $stable(sel_idx));  // R9
  AST_ERR_RANGE: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> ($past(bus_req) && (int'($past(bus_addr)) >= NUM_WORDS)));  // R10
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> (bus_rdata == '0));  // R10
endmodule

bind rx_slot_mgr rxd_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)
) i_rxd_checker (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .bus_err(bus_err), .frm_start(frm_start), .frm_done(frm_done), .rx_irq(rx_irq),
  .rx_ready(rx_ready), .rx_rst(rx_rst), .sel_idx(sel_idx), .sel_ok(sel_ok),
  .slot_state(slot_state)
);

// File: tb/test_rx_slot_mgr.sv
module test_rx_slot_mgr;
  localparam int DW = 32;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_req = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          bus_err;
  logic          frm_start = 1'b0, frm_done = 1'b0;
  logic [DW-1:0] frm_len = '0;
  logic [DW-1:0] wr_base;
  logic          wr_go, rx_irq, rx_ready;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  rx_slot_mgr #(.DATA_W(DW), .ADDR_W(AW), .NUM_SLOTS(4)) i_rx_slot_mgr (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .frm_start(frm_start), .frm_done(frm_done), .frm_len(frm_len),
    .wr_base(wr_base), .wr_go(wr_go), .rx_irq(rx_irq), .rx_ready(rx_ready)
  );

  always #10 clk = ~clk;

  function automatic int st_w(int k); return 2 + 3 * k; endfunction
  function automatic int ad_w(int k); return 3 + 3 * k; endfunction
  function automatic int cn_w(int k); return 4 + 3 * k; endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(int a, logic [DW-1:0] d, output logic err);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    err = bus_err;
  endtask

  task automatic bus_rd(int a, output logic [DW-1:0] d, output logic err);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = AW'(a);
    @(posedge clk);
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata; err = bus_err;
  endtask

  task automatic wr(int a, logic [DW-1:0] d);
    logic e;
    bus_wr(a, d, e);
  endtask

  task automatic rd_chk(string req, int a, logic [DW-1:0] exp);
    logic [DW-1:0] d; logic e;
    bus_rd(a, d, e);
    chk(req, d, exp);
  endtask

  task automatic start_frame();
    @(negedge clk); frm_start = 1'b1;
    @(posedge clk);
    @(negedge clk); frm_start = 1'b0;
  endtask

  task automatic done_frame(logic [DW-1:0] len);
    @(negedge clk); frm_done = 1'b1; frm_len = len;
    @(posedge clk);
    @(negedge clk); frm_done = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d; logic e;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    settle();
    // R1: state after reset
    chk("R1 irq", DW'(rx_irq), 0);
    chk("R1 wr_go", DW'(wr_go), 0);
    chk("R1 ready", DW'(rx_ready), 0);
    chk("R1 err", DW'(bus_err), 0);
    chk("R1 rdata", bus_rdata, 0);
    for (int w = 0; w < 16; w++) rd_chk("R1 word", w, 0);

    // R2: every word round trips
    for (int w = 0; w < 16; w++) wr(w, 32'hC0DE_0000 + DW'(w * 32'h111) + 32'h100);
    for (int w = 0; w < 16; w++) rd_chk("R2 word", w, 32'hC0DE_0000 + DW'(w * 32'h111) + 32'h100);
    for (int w = 0; w < 16; w++) wr(w, 0);

    // R3 R4 R5 R6 R8: sweep all loaded-slot patterns
    for (int p = 0; p < 16; p++) begin
      int sel; logic [DW-1:0] len;
      sel = -1;
      for (int k = 3; k >= 0; k--) if (p[k]) sel = k;
      for (int k = 0; k < 4; k++) begin
        wr(st_w(k), p[k] ? 1 : ((k % 2 == 1) ? 2 : 0));
        wr(ad_w(k), 32'h4000_0000 + DW'(k << 8) + DW'(p));
        wr(cn_w(k), 32'hAA + DW'(k));
      end
      settle();
      chk("R8 ready sweep", DW'(rx_ready), DW'(p != 0));
      start_frame();
      chk("R3 R6 wr_go", DW'(wr_go), DW'(p != 0));
      if (sel >= 0) chk("R3 wr_base", wr_base, 32'h4000_0000 + DW'(sel << 8) + DW'(p));
      len = 100 + DW'(p);
      done_frame(len);
      chk("R5 R6 irq", DW'(rx_irq), DW'(p != 0));
      settle();
      chk("R5 irq single", DW'(rx_irq), 0);
      for (int k = 0; k < 4; k++) begin
        rd_chk("R4 R6 state", st_w(k), (k == sel) ? 2 : (p[k] ? 1 : ((k % 2 == 1) ? 2 : 0)));
        rd_chk("R4 R6 count", cn_w(k), (k == sel) ? len : 32'hAA + DW'(k));
      end
    end

    // R7 R8: receive reset discards
    for (int k = 0; k < 4; k++) wr(st_w(k), 0);
    wr(cn_w(0), 32'h55);
    wr(0, 1);
    wr(st_w(0), 1);
    settle();
    chk("R8 ready rst+loaded", DW'(rx_ready), 1);
    start_frame();
    chk("R7 wr_go", DW'(wr_go), 0);
    done_frame(32'h99);
    chk("R7 irq", DW'(rx_irq), 0);
    rd_chk("R7 state kept", st_w(0), 1);
    rd_chk("R7 count kept", cn_w(0), 32'h55);
    wr(st_w(0), 0);
    settle();
    chk("R8 ready rst only", DW'(rx_ready), 1);
    wr(0, 0);
    settle();
    chk("R8 ready none", DW'(rx_ready), 0);

    // R9: selection latched at start
    wr(ad_w(1), 32'h5000);
    wr(st_w(1), 1);
    start_frame();
    chk("R9 base at start", wr_base, 32'h5000);
    wr(st_w(1), 0);
    wr(st_w(0), 1);
    wr(ad_w(1), 32'h6000);
    chk("R9 base held", wr_base, 32'h5000);
    done_frame(77);
    chk("R9 irq", DW'(rx_irq), 1);
    rd_chk("R9 slot1 state", st_w(1), 2);
    rd_chk("R9 slot1 count", cn_w(1), 77);
    rd_chk("R9 slot0 state", st_w(0), 1);
    rd_chk("R9 slot0 count", cn_w(0), 32'h55);

    // R10: out-of-range accesses
    bus_wr(16, 32'hFFFF_FFFF, e);
    chk("R10 err write", DW'(e), 1);
    bus_wr(18, 32'h0, e);
    chk("R10 err write2", DW'(e), 1);
    bus_rd(16, d, e);
    chk("R10 err read", DW'(e), 1);
    chk("R10 rdata zero", d, 0);
    bus_rd(63, d, e);
    chk("R10 err top", DW'(e), 1);
    chk("R10 rdata top", d, 0);
    bus_rd(0, d, e);
    chk("R10 no alias setup", d, 0);
    chk("R10 no err in range", DW'(e), 0);
    rd_chk("R10 no alias state", st_w(0), 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule